// File: doc/BRIEF.md
# Marker Sync Flywheel

This block decides whether a receiver's frame timing can be trusted when the frame marker is a bit pattern that can also turn up inside ordinary data. What sets the true marker apart is that it repeats with a fixed spacing. A saturating up/down counter adds up the outcome of every expected marker slot. Each slot either finds the marker (a hit) or misses it. The block opens an enable gate only after enough hits in a row and closes it only after misses have drained the counter, so that a few noisy slots do not toggle it.

While enabled, slots come from the timing chain's end-of-count pulse. A hit in such a slot is forwarded as a start pulse that restarts the chain. Once the counter empties, the gate closes and the block hunts for the marker on its own. The first match seen on a bit strobe opens a candidate position. After that, only matches exactly one frame (`FRAME_BITS` strobes) later count as hits. A miss at the candidate's slot drops the candidate. The hit that refills the counter to `MAX_HITS` reopens the gate and sends a start pulse in the same cycle, which restarts the chain at the recovered position. The data shift path is outside this block and is never gated by it.

Top module: `sync_flywheel`

## Requirements
- R1: During and straight after reset, `lock_cnt_o` is 0, `sync_en_o` is 0 and `chain_start_o` is 0.
- R2: While enabled, a cycle with `eoc_arm_i`=1 and `marker_hit_i`=1 is a hit. A hit raises `lock_cnt_o` by one on the next edge, or holds it at `MAX_HITS` if it is already there. `chain_start_o` is 1 in that same cycle.
- R3: While enabled, a cycle with `eoc_arm_i`=1 and `marker_hit_i`=0 is a miss. A miss lowers `lock_cnt_o` by one. `sync_en_o` stays 1 as long as the count stays above 0, so with `MAX_HITS`=4 two misses from full leave the block enabled.
- R4: The edge that brings `lock_cnt_o` to 0 also drops `sync_en_o`. From then on no start pulse reaches `chain_start_o` until R5 applies.
- R5: `sync_en_o` rises only on the edge at which `lock_cnt_o` reaches `MAX_HITS`. The hit that causes this drives `chain_start_o`=1 in its own cycle. Hits below `MAX_HITS` while disabled give no start pulse.
- R6: While disabled, `eoc_arm_i` has no effect. The first `marker_hit_i`=1 seen on a `bit_strobe_i` cycle with no open candidate only opens a candidate and leaves the count unchanged.
- R7: While disabled with a candidate open, the `FRAME_BITS`-th strobe after the sighting (or after the candidate's last slot) is a slot. A match there is a hit. No match there is a miss: the count decreases but never goes below 0, and the candidate is dropped.
- R8: `marker_hit_i` outside a slot has no effect on any output. This covers a match without `eoc_arm_i` while enabled, and a match on a non-slot strobe while a candidate is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_strobe_i | input | 1 | One pulse per received bit; paces the hunt |
| eoc_arm_i | input | 1 | End-of-count pulse from the timing chain marking an expected marker slot |
| marker_hit_i | input | 1 | Marker pattern matches in this cycle |
| chain_start_o | output | 1 | Gated start pulse to the timing chain |
| sync_en_o | output | 1 | Lock enable for the receive and transmit logic |
| lock_cnt_o | output | $clog2(MAX_HITS+1) | Current integrator count |

## Verification
Two things can happen in the same cycle. The hit that completes the refill must both pass a start pulse and raise the enable. The first can only be judged in that cycle, from the next-state enable, and the second only after the edge. The bench runs full refills in hunt mode and checks each time that `chain_start_o` is high in the refill cycle, and that `sync_en_o` with a full count follows on the next edge. It also feeds end-of-count pulses and matches on non-slot strobes during the hunt. These must leave both the count and the start output unchanged.

// File: rtl/sync_flywheel_pkg.sv
package sync_flywheel_pkg;

  // saturating integrator step: up wins over down, clamps at 0 and at top
  function automatic int step_count(int cur, logic up, logic dn, int top);
    if (up && cur < top) return cur + 1;
    if (dn && cur > 0)   return cur - 1;
    return cur;
  endfunction

  // hysteresis: empty closes, full opens, anything between holds
  function automatic logic next_enable(logic cur_en, int nxt, int top);
    if (nxt == 0)   return 1'b0;
    if (nxt == top) return 1'b1;
    return cur_en;
  endfunction

endpackage

// File: rtl/flywheel_slot_sel.sv
module flywheel_slot_sel #(
  parameter int FRAME_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic strobe_i,
  input  logic arm_i,
  input  logic match_i,
  output logic hit_o,
  output logic miss_o
);
  localparam int GW = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
  localparam logic [GW-1:0] LAST = GW'(FRAME_BITS - 1);

  logic          cand_q;
  logic [GW-1:0] gap_q;
  logic          hunt_slot;
  logic          slot;

  assign hunt_slot = !en_i && cand_q && strobe_i && (gap_q == LAST);
  assign slot      = en_i ? arm_i : hunt_slot;
  assign hit_o     = slot && match_i;
  assign miss_o    = slot && !match_i;

  always_ff @(posedge clk) begin
    if (!rst_n || en_i) begin
      cand_q <= 1'b0;
      gap_q  <= '0;
    end else if (strobe_i) begin
      if (!cand_q) begin
        if (match_i) begin
          cand_q <= 1'b1;
          gap_q  <= '0;
        end
      end else if (gap_q == LAST) begin
        gap_q <= '0;
        if (!match_i) cand_q <= 1'b0;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flywheel_integrator.sv
module flywheel_integrator
  import sync_flywheel_pkg::*;
#(
  parameter int MAX_HITS = 4,
  localparam int CW = $clog2(MAX_HITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic          miss_i,
  output logic [CW-1:0] cnt_o,
  output logic          en_o,
  output logic          en_next_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en_q;

  assign cnt_d     = CW'(step_count(int'(cnt_q), hit_i, miss_i, MAX_HITS));
  assign en_next_o = next_enable(en_q, int'(cnt_d), MAX_HITS);
  assign cnt_o     = cnt_q;
  assign en_o      = en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_next_o;
    end
  end
endmodule

// File: rtl/sync_flywheel.sv
module sync_flywheel #(
  parameter int MAX_HITS   = 4,
  parameter int FRAME_BITS = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bit_strobe_i,
  input  logic                          eoc_arm_i,
  input  logic                          marker_hit_i,
  output logic                          chain_start_o,
  output logic                          sync_en_o,
  output logic [$clog2(MAX_HITS+1)-1:0] lock_cnt_o
);
  // named internal events, visible to the bound checker
  logic slot_hit;
  logic slot_miss;
  logic en_next;

  flywheel_slot_sel #(.FRAME_BITS(FRAME_BITS)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (sync_en_o),
    .strobe_i (bit_strobe_i),
    .arm_i    (eoc_arm_i),
    .match_i  (marker_hit_i),
    .hit_o    (slot_hit),
    .miss_o   (slot_miss)
  );

  flywheel_integrator #(.MAX_HITS(MAX_HITS)) u_integ (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_i     (slot_hit),
    .miss_i    (slot_miss),
    .cnt_o     (lock_cnt_o),
    .en_o      (sync_en_o),
    .en_next_o (en_next)
  );

  // a hit passes when the gate is open after this edge (covers the refill hit)
  assign chain_start_o = slot_hit && en_next;
endmodule

// File: rtl/sync_flywheel_chk.sv
module sync_flywheel_chk #(
  parameter int MAX_HITS = 4,
  localparam int CW = $clog2(MAX_HITS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_strobe_i,
  input logic          chain_start_o,
  input logic          sync_en_o,
  input logic [CW-1:0] lock_cnt_o,
  input logic          slot_hit,
  input logic          slot_miss
);
  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_cnt_o <= CW'(MAX_HITS));

  // R4
  en_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_en_o |-> lock_cnt_o != '0);

  // R5
  rise_at_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_en_o) |-> lock_cnt_o == CW'(MAX_HITS));

  // R5
  start_then_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_start_o |=> sync_en_o);

  // R3
  miss_steps_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_miss && lock_cnt_o != '0) |=> lock_cnt_o == $past(lock_cnt_o) - 1'b1);

  // R6
  hunt_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_en_o && !bit_strobe_i) |=> $stable(lock_cnt_o));

  // R8
  no_slot_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_hit && !slot_miss) |=> $stable(lock_cnt_o));
endmodule

bind sync_flywheel sync_flywheel_chk #(.MAX_HITS(MAX_HITS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bit_strobe_i  (bit_strobe_i),
  .chain_start_o (chain_start_o),
  .sync_en_o     (sync_en_o),
  .lock_cnt_o    (lock_cnt_o),
  .slot_hit      (slot_hit),
  .slot_miss     (slot_miss)
);

// File: tb/test_sync_flywheel.sv
module test_sync_flywheel;
  localparam int X  = 4;
  localparam int FB = 5;
  localparam int CW = $clog2(X + 1);

  typedef struct {
    bit    start;
    bit    en;
    int    cnt;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0, arm = 1'b0, mt = 1'b0;
  logic          start_w, en_w;
  logic [CW-1:0] cnt_w;

  int checks = 0, errors = 0;
  exp_t q[$];
  bit done = 1'b0;

  // reference state
  int m_cnt = 0, m_gap = 0;
  bit m_en = 1'b0, m_cand = 1'b0;

  always #2 clk = ~clk;

  sync_flywheel #(.MAX_HITS(X), .FRAME_BITS(FB)) i_sync_flywheel (
    .clk(clk), .rst_n(rst_n), .bit_strobe_i(stb), .eoc_arm_i(arm),
    .marker_hit_i(mt), .chain_start_o(start_w), .sync_en_o(en_w), .lock_cnt_o(cnt_w)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and predict its outcome
  task automatic drive(bit s, bit a, bit m, string tag);
    bit slot, h, ms, ne;
    int nc;
    exp_t e;
    @(negedge clk);
    stb = s; arm = a; mt = m;
    slot = m_en ? a : (s && m_cand && m_gap == FB - 1);
    h  = slot && m;
    ms = slot && !m;
    nc = m_cnt;
    if (h && m_cnt < X) nc = m_cnt + 1;
    else if (ms && m_cnt > 0) nc = m_cnt - 1;
    ne = (nc == 0) ? 1'b0 : (nc == X) ? 1'b1 : m_en;
    e.start = h && ne; e.en = ne; e.cnt = nc; e.tag = tag;
    q.push_back(e);
    if (m_en) begin
      m_cand = 1'b0; m_gap = 0;
    end else if (s) begin
      if (!m_cand) begin
        if (m) begin m_cand = 1'b1; m_gap = 0; end
      end else if (m_gap == FB - 1) begin
        m_gap = 0;
        if (!m) m_cand = 1'b0;
      end else m_gap++;
    end
    m_cnt = nc; m_en = ne;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 0, tag);
  endtask

  // strobe with one idle gap, as a slow bit clock
  task automatic bit_in(bit m, string tag);
    drive(1, 0, m, tag);
    idle(1, tag);
  endtask

  // monitor: pop predictions and compare at safe sample points
  initial begin
    bit s;
    exp_t e;
    @(posedge rst_n);
    forever begin
      @(negedge clk); #1;
      s = start_w;
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(e.tag, "start", int'(s), int'(e.start));
        check(e.tag, "enable", int'(en_w), int'(e.en));
        check(e.tag, "count", int'(cnt_w), e.cnt);
      end
    end
  end

  // refill while hunting: sighting, four filler strobes, then X slot hits
  task automatic refill(string tag);
    bit_in(1, "R6");
    for (int k = 0; k < X; k++) begin
      bit_in(1, "R8");
      for (int j = 0; j < FB - 2; j++) bit_in(0, "R8");
      drive(0, 1, 1, "R6");
      bit_in(1, tag);
    end
  endtask

  initial begin
    stb = 1'b1; arm = 1'b1; mt = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1
    check("R1", "count", int'(cnt_w), 0);
    check("R1", "enable", int'(en_w), 0);
    check("R1", "start", int'(start_w), 0);
    @(negedge clk);
    stb = 1'b0; arm = 1'b0; mt = 1'b0;
    rst_n = 1'b1;
    idle(2, "R1");
    // R6: arms with matches are ignored while hunting
    drive(0, 1, 1, "R6"); drive(0, 1, 1, "R6");
    idle(1, "R6");
    // R7: candidate slot without a match, count stays at zero, candidate drops
    bit_in(1, "R6");
    for (int j = 0; j < FB - 1; j++) bit_in(0, "R7");
    bit_in(0, "R7");
    bit_in(0, "R7");
    // R5: full refill reopens the gate with a start pulse
    refill("R5");
    idle(2, "R5");
    // R2: enabled hits saturate and pass starts; R8 stray match ignored
    drive(0, 1, 1, "R2"); idle(1, "R2");
    drive(0, 0, 1, "R8"); drive(1, 0, 1, "R8");
    drive(0, 1, 1, "R2");
    // R3: two misses keep the gate open, a hit climbs back
    drive(0, 1, 0, "R3"); idle(1, "R3");
    drive(0, 1, 0, "R3"); drive(0, 1, 1, "R2");
    drive(0, 1, 0, "R3"); drive(0, 1, 0, "R3");
    // R4: draining to zero closes the gate, further arms blocked
    drive(0, 1, 0, "R4");
    drive(0, 1, 0, "R4"); drive(0, 1, 1, "R4");
    idle(1, "R4");
    // R7: partial refill then a slot miss steps the count down
    bit_in(1, "R6");
    for (int j = 0; j < FB - 1; j++) bit_in(0, "R7");
    bit_in(1, "R7");
    for (int j = 0; j < FB - 1; j++) bit_in(1, "R8");
    bit_in(1, "R7");
    for (int j = 0; j < FB - 1; j++) bit_in(0, "R7");
    bit_in(0, "R7");
    // R5: second refill from a partial count
    refill("R5");
    idle(3, "R5");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule